// File: doc/BRIEF.md
# I2C Register Access Slave

This block is a 7-bit-addressed I2C slave that lets a bus master read and write a bank of 8-bit registers held outside the block. SCL and SDA arrive as raw bus levels and are synchronised into a fast system clock. The system clock must run at least ten times faster than SCL, and SCL may run anywhere from a standstill up to 400 kHz. The block pulls SDA low through an open-drain enable and never drives it high.

A write transfer carries the device address with the direction bit clear, then a register-pointer byte, then any number of data bytes. Each data byte produces a one-cycle write strobe toward the register file. A read transfer sets the pointer the same way, then issues a repeated START and the device address with the direction bit set. The slave then returns bytes until the master answers one with NACK.

After every data byte, whether read or written, the pointer advances only if it lies inside an address window marked as incrementing. The default has 0x00–0x0F incrementing and 0x10–0x1F fixed. Addresses outside every window stay fixed. The register port has no back-pressure: the register file must accept a strobe in any cycle, and it must return read data combinationally for the address it is shown.

Top module: `i2c_regbank_slave`

## Requirements
- R1: While reset is held and directly after it, sda_oe and reg_we are 0 and reg_addr is 0x00.
- R2: Until a START (SDA falling while SCL is high) has been seen, clocked bytes get no ACK and cause no write strobe.
- R3: After a START, an address byte whose upper 7 bits equal the device address (default 0x42) is acknowledged by pulling SDA low during the ninth clock. On a mismatch the slave neither ACKs nor strobes anything until the next START.
- R4: In a write transfer, the byte after the address loads reg_addr and is acknowledged. Each following byte is acknowledged and produces exactly one reg_we pulse, with reg_wdata equal to the byte and reg_addr equal to the current pointer, while SCL is low.
- R5: After each written byte, the pointer increments if it lies in 0x00–0x0F. It holds if it lies in 0x10–0x1F or outside every window. This applies across window edges (a burst at 0x0E writes 0x0E, 0x0F, 0x10, 0x10).
- R6: After a repeated START with the direction bit set, the slave sends the register data at the pointer MSB first, changing SDA only while SCL is low. Each byte sent applies the R5 pointer rule, and a master ACK requests the next byte.
- R7: After a master NACK the slave releases SDA and sends nothing (the bus reads 0xFF) until the next START.
- R8: A STOP (SDA rising while SCL is high) ends a write burst. Bytes clocked after it without a new START cause no ACK and no strobe.
- R9: sda_oe changes only while synchronised SCL is low, and it is 0 in the cycle after any detected START or STOP.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 10x SCL |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | SCL bus level |
| sda_i | input | 1 | SDA bus level |
| sda_oe | output | 1 | 1 pulls SDA low |
| reg_addr | output | 8 | Register pointer presented to the register file |
| reg_wdata | output | 8 | Write data for the register file |
| reg_we | output | 1 | One-cycle write strobe |
| reg_rdata | input | 8 | Combinational read data for reg_addr |

## Verification
Every bus edge reaches the state machine through the synchroniser plus one detect register. An ACK or a read data bit therefore appears on sda_oe about four system cycles after the SCL fall that begins its bit period. A write strobe appears at the SCL fall that opens the ninth clock. The bench changes SDA only at the start of a 20-cycle SCL-low half period, samples the bus halfway through SCL high, and reads the strobe log and reg_addr only after the ninth clock has ended, so every result has long since settled. Pointer and data expectations come from a bench-side register image and window rule, and are compared after every byte.

// File: rtl/i2c_slv_pkg.sv
`timescale 1ns/1ps
package i2c_slv_pkg;
  localparam int BYTE_W = 8;
  localparam int ADR_W  = 7;

  typedef logic [BYTE_W-1:0] byte_t;

  typedef enum logic [3:0] {
    ST_IDLE,   // waiting for START
    ST_ADDR,   // shifting in device address
    ST_AACK,   // driving ACK for address
    ST_PTR,    // shifting in register pointer
    ST_PACK,   // driving ACK for pointer
    ST_WR,     // shifting in write data
    ST_WACK,   // driving ACK for write data
    ST_RD,     // shifting out read data
    ST_RACK,   // sampling master ACK/NACK
    ST_SKIP    // silent until next START
  } slv_state_t;
endpackage

// File: rtl/i2c_line_sync.sv
`timescale 1ns/1ps
module i2c_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_lvl,
  output logic sda_lvl,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic [STAGES-1:0] scl_chain, sda_chain;
  logic              scl_prev, sda_prev;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          scl_chain <= '1;
          sda_chain <= '1;
        end else begin
          scl_chain <= scl_i;
          sda_chain <= sda_i;
        end
      end
    end else begin : g_many
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          scl_chain <= '1;
          sda_chain <= '1;
        end else begin
          scl_chain <= {scl_chain[STAGES-2:0], scl_i};
          sda_chain <= {sda_chain[STAGES-2:0], sda_i};
        end
      end
    end
  endgenerate

  assign scl_lvl = scl_chain[STAGES-1];
  assign sda_lvl = sda_chain[STAGES-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_prev <= 1'b1;
      sda_prev <= 1'b1;
    end else begin
      scl_prev <= scl_lvl;
      sda_prev <= sda_lvl;
    end
  end

  // Start and stop only count while SCL has been high for two samples.
  assign scl_rise  =  scl_lvl & ~scl_prev;
  assign scl_fall  = ~scl_lvl &  scl_prev;
  assign start_det =  scl_lvl &  scl_prev &  sda_prev & ~sda_lvl;
  assign stop_det  =  scl_lvl &  scl_prev & ~sda_prev &  sda_lvl;
endmodule

// File: rtl/i2c_ptr_unit.sv
`timescale 1ns/1ps
module i2c_ptr_unit
  import i2c_slv_pkg::*;
#(
  parameter int                    NUM_WIN = 2,
  parameter logic [NUM_WIN*BYTE_W-1:0] WIN_LO  = {8'h10, 8'h00},
  parameter logic [NUM_WIN*BYTE_W-1:0] WIN_HI  = {8'h1F, 8'h0F},
  parameter logic [NUM_WIN-1:0]    WIN_INC = 2'b01
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  load,
  input  byte_t load_val,
  input  logic  step,
  output byte_t ptr
);
  logic [NUM_WIN-1:0] hit;
  logic               inc_ok;
  logic               found;

  generate
    for (genvar w = 0; w < NUM_WIN; w++) begin : g_win
      byte_t offs, span;
      // Unsigned offset test avoids a constant compare against zero.
      assign offs   = ptr - WIN_LO[w*BYTE_W +: BYTE_W];
      assign span   = WIN_HI[w*BYTE_W +: BYTE_W] - WIN_LO[w*BYTE_W +: BYTE_W];
      assign hit[w] = (offs <= span);
    end
  endgenerate

  // Lowest-numbered matching window decides.
  always_comb begin
    inc_ok = 1'b0;
    found  = 1'b0;
    for (int w = 0; w < NUM_WIN; w++) begin
      if (hit[w] && !found) begin
        found  = 1'b1;
        inc_ok = WIN_INC[w];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               ptr <= '0;
    else if (load)            ptr <= load_val;
    else if (step && inc_ok)  ptr <= ptr + byte_t'(1);
  end
endmodule

// File: rtl/i2c_regbank_slave.sv
`timescale 1ns/1ps
module i2c_regbank_slave
  import i2c_slv_pkg::*;
#(
  parameter logic [ADR_W-1:0]          DEV_ADDR    = 7'h42,
  parameter int                        SYNC_STAGES = 2,
  parameter int                        NUM_WIN     = 2,
  parameter logic [NUM_WIN*BYTE_W-1:0] WIN_LO      = {8'h10, 8'h00},
  parameter logic [NUM_WIN*BYTE_W-1:0] WIN_HI      = {8'h1F, 8'h0F},
  parameter logic [NUM_WIN-1:0]        WIN_INC     = 2'b01
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe,
  output logic [BYTE_W-1:0] reg_addr,
  output logic [BYTE_W-1:0] reg_wdata,
  output logic              reg_we,
  input  logic [BYTE_W-1:0] reg_rdata
);
  localparam int CNT_W = $clog2(BYTE_W + 1);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(BYTE_W);

  logic scl_lvl, sda_lvl, scl_rise, scl_fall, start_det, stop_det;

  i2c_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_i     (scl_i),
    .sda_i     (sda_i),
    .scl_lvl   (scl_lvl),
    .sda_lvl   (sda_lvl),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_det (start_det),
    .stop_det  (stop_det)
  );

  slv_state_t          st;
  logic [CNT_W-1:0]    bit_cnt;
  byte_t               rx_sh;
  logic [BYTE_W-2:0]   tx_sh;
  logic                rw_q, m_ack_q, oe_q, we_q, ld_q, rd_adv_q;
  byte_t               wdata_q;
  byte_t               ptr;

  i2c_ptr_unit #(
    .NUM_WIN (NUM_WIN),
    .WIN_LO  (WIN_LO),
    .WIN_HI  (WIN_HI),
    .WIN_INC (WIN_INC)
  ) u_ptr (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (ld_q),
    .load_val (rx_sh),
    .step     (we_q | rd_adv_q),
    .ptr      (ptr)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= ST_IDLE;
      bit_cnt  <= '0;
      rx_sh    <= '0;
      tx_sh    <= '0;
      rw_q     <= 1'b0;
      m_ack_q  <= 1'b0;
      oe_q     <= 1'b0;
      we_q     <= 1'b0;
      ld_q     <= 1'b0;
      rd_adv_q <= 1'b0;
      wdata_q  <= '0;
    end else begin
      we_q     <= 1'b0;
      ld_q     <= 1'b0;
      rd_adv_q <= 1'b0;
      if (start_det) begin
        st      <= ST_ADDR;
        bit_cnt <= '0;
        oe_q    <= 1'b0;
      end else if (stop_det) begin
        st      <= ST_IDLE;
        bit_cnt <= '0;
        oe_q    <= 1'b0;
      end else begin
        case (st)
          ST_ADDR, ST_PTR, ST_WR: begin
            if (scl_rise && bit_cnt < FULL) begin
              rx_sh   <= {rx_sh[BYTE_W-2:0], sda_lvl};
              bit_cnt <= bit_cnt + CNT_W'(1);
            end else if (scl_fall && bit_cnt == FULL) begin
              bit_cnt <= '0;
              if (st == ST_ADDR) begin
                if (rx_sh[BYTE_W-1:1] == DEV_ADDR) begin
                  oe_q <= 1'b1;
                  rw_q <= rx_sh[0];
                  st   <= ST_AACK;
                end else begin
                  st   <= ST_SKIP;
                end
              end else if (st == ST_PTR) begin
                oe_q <= 1'b1;
                ld_q <= 1'b1;
                st   <= ST_PACK;
              end else begin
                oe_q    <= 1'b1;
                we_q    <= 1'b1;
                wdata_q <= rx_sh;
                st      <= ST_WACK;
              end
            end
          end
          ST_AACK: begin
            if (scl_fall) begin
              bit_cnt <= '0;
              if (rw_q) begin
                tx_sh <= reg_rdata[BYTE_W-2:0];
                oe_q  <= ~reg_rdata[BYTE_W-1];
                st    <= ST_RD;
              end else begin
                oe_q  <= 1'b0;
                st    <= ST_PTR;
              end
            end
          end
          ST_PACK, ST_WACK: begin
            if (scl_fall) begin
              oe_q    <= 1'b0;
              bit_cnt <= '0;
              st      <= ST_WR;
            end
          end
          ST_RD: begin
            if (scl_rise) begin
              bit_cnt <= bit_cnt + CNT_W'(1);
            end else if (scl_fall) begin
              if (bit_cnt == FULL) begin
                oe_q     <= 1'b0;
                rd_adv_q <= 1'b1;
                bit_cnt  <= '0;
                st       <= ST_RACK;
              end else begin
                oe_q  <= ~tx_sh[BYTE_W-2];
                tx_sh <= {tx_sh[BYTE_W-3:0], 1'b0};
              end
            end
          end
          ST_RACK: begin
            if (scl_rise) begin
              m_ack_q <= ~sda_lvl;
            end else if (scl_fall) begin
              if (m_ack_q) begin
                tx_sh <= reg_rdata[BYTE_W-2:0];
                oe_q  <= ~reg_rdata[BYTE_W-1];
                st    <= ST_RD;
              end else begin
                st    <= ST_SKIP;
              end
            end
          end
          default: ;  // idle and skip wait for START
        endcase
      end
    end
  end

  assign sda_oe    = oe_q;
  assign reg_we    = we_q;
  assign reg_wdata = wdata_q;
  assign reg_addr  = ptr;
endmodule

// File: rtl/i2c_regbank_slave_chk.sv
`timescale 1ns/1ps
module i2c_regbank_slave_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       scl_lvl,
  input logic       start_det,
  input logic       stop_det,
  input logic       sda_oe,
  input logic       reg_we,
  input logic [7:0] reg_addr
);
  assert_oe_scl_low_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_oe) |-> !scl_lvl);
  assert_release_stop_R9: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> !sda_oe);
  assert_release_start_R9: assert property (@(posedge clk) disable iff (!rst_n)
    start_det |=> !sda_oe);
  assert_we_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we |=> !reg_we);
  assert_we_scl_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we |-> !scl_lvl);
  assert_addr_steady_R4: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we |-> $stable(reg_addr));
endmodule

bind i2c_regbank_slave i2c_regbank_slave_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .scl_lvl   (scl_lvl),
  .start_det (start_det),
  .stop_det  (stop_det),
  .sda_oe    (sda_oe),
  .reg_we    (reg_we),
  .reg_addr  (reg_addr)
);

// File: tb/i2c_regbank_slave_test.sv
`timescale 1ns/1ps
module i2c_regbank_slave_test;
  localparam int H = 20;
  localparam logic [6:0] DEV = 7'h42;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic scl_m = 1'b1, sda_m = 1'b1;
  logic sda_oe, reg_we;
  logic [7:0] reg_addr, reg_wdata, reg_rdata;
  logic sda_bus;
  assign sda_bus = sda_m & ~sda_oe;

  logic [7:0] mem [256];
  logic [7:0] em  [256];
  logic [7:0] dbuf [8];
  assign reg_rdata = mem[reg_addr];

  int checks = 0, errs = 0, wcnt = 0;
  logic [7:0] w_addr = '0, w_data = '0;

  always @(posedge clk) begin
    if (rst_n && reg_we) begin
      mem[reg_addr] <= reg_wdata;
      wcnt   <= wcnt + 1;
      w_addr <= reg_addr;
      w_data <= reg_wdata;
    end
  end

  i2c_regbank_slave uut (
    .clk (clk), .rst_n (rst_n), .scl_i (scl_m), .sda_i (sda_bus),
    .sda_oe (sda_oe), .reg_addr (reg_addr), .reg_wdata (reg_wdata),
    .reg_we (reg_we), .reg_rdata (reg_rdata)
  );

  function automatic logic [7:0] nxt(input logic [7:0] p);
    return (p <= 8'h0F) ? p + 8'd1 : p;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wt(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; wt(H); scl_m = 1'b1; wt(H); sda_m = 1'b0; wt(H); scl_m = 1'b0; wt(H);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; wt(H); scl_m = 1'b1; wt(H); sda_m = 1'b1; wt(H);
  endtask

  task automatic clk_bit(input logic b, output logic seen);
    sda_m = b; wt(H); scl_m = 1'b1; wt(H/2); seen = sda_bus; wt(H/2); scl_m = 1'b0;
  endtask

  task automatic write_byte(input logic [7:0] b, output logic ack);
    logic s;
    for (int i = 7; i >= 0; i--) clk_bit(b[i], s);
    clk_bit(1'b1, s);
    ack = ~s;
  endtask

  task automatic read_byte(output logic [7:0] b, input logic mack);
    logic s;
    b = '0;
    for (int i = 0; i < 8; i++) begin
      clk_bit(1'b1, s);
      b = {b[6:0], s};
    end
    clk_bit(~mack, s);
  endtask

  task automatic wr_burst(input logic [7:0] p, input int n);
    logic a; logic [7:0] ep; int c0;
    bus_start();
    write_byte({DEV, 1'b0}, a);  chk("R3 address ack", a, 1);
    write_byte(p, a);            chk("R4 pointer ack", a, 1);
    chk("R4 pointer load", reg_addr, p);
    ep = p;
    for (int i = 0; i < n; i++) begin
      c0 = wcnt;
      write_byte(dbuf[i], a);
      chk("R4 data ack", a, 1);
      chk("R4 one strobe", wcnt, c0 + 1);
      chk("R4 strobe address", w_addr, ep);
      chk("R4 strobe data", w_data, dbuf[i]);
      em[ep] = dbuf[i];
      ep = nxt(ep);
      chk("R5 pointer after write", reg_addr, ep);
    end
    bus_stop();
    chk("R9 released after stop", sda_oe, 0);
  endtask

  task automatic rd_burst(input logic [7:0] p, input int n);
    logic a; logic [7:0] ep, b;
    bus_start();
    write_byte({DEV, 1'b0}, a);  chk("R3 address ack", a, 1);
    write_byte(p, a);            chk("R4 pointer ack", a, 1);
    bus_start();
    write_byte({DEV, 1'b1}, a);  chk("R6 read address ack", a, 1);
    ep = p;
    for (int i = 0; i < n; i++) begin
      read_byte(b, i < n - 1);
      chk("R6 read data", b, em[ep]);
      ep = nxt(ep);
    end
    chk("R6 pointer after read", reg_addr, ep);
    bus_stop();
  endtask

  initial begin
    logic a; logic [7:0] b; int c0; logic [7:0] p; int n;
    void'($urandom(32'd4242));
    for (int i = 0; i < 256; i++) begin
      mem[i] = 8'(i) ^ 8'hA5;
      em[i]  = 8'(i) ^ 8'hA5;
    end
    wt(5);
    chk("R1 sda_oe in reset", sda_oe, 0);
    chk("R1 reg_we in reset", reg_we, 0);
    rst_n = 1'b1;
    wt(3);
    chk("R1 reg_addr after reset", reg_addr, 8'h00);
    chk("R1 sda_oe after reset", sda_oe, 0);

    // R2: bytes with no START
    scl_m = 1'b0; wt(H);
    c0 = wcnt;
    write_byte({DEV, 1'b0}, a); chk("R2 no ack without start", a, 0);
    write_byte(8'h33, a);       chk("R2 no ack on data", a, 0);
    chk("R2 no strobe", wcnt, c0);
    bus_stop();

    // R3: wrong device address
    bus_start();
    write_byte({7'h43, 1'b0}, a); chk("R3 mismatch nack", a, 0);
    write_byte(8'h01, a);         chk("R3 silent after mismatch", a, 0);
    write_byte(8'h55, a);         chk("R3 silent data", a, 0);
    chk("R3 no strobe", wcnt, c0);
    bus_stop();

    // R5: burst across the edge of the incrementing window
    dbuf[0] = 8'h11; dbuf[1] = 8'h22; dbuf[2] = 8'h33; dbuf[3] = 8'h44;
    wr_burst(8'h0E, 4);
    chk("R5 final pointer at boundary", reg_addr, 8'h10);

    // R8: bytes after STOP without START
    c0 = wcnt;
    scl_m = 1'b0; wt(H);
    write_byte(8'h77, a); chk("R8 no ack after stop", a, 0);
    chk("R8 no strobe after stop", wcnt, c0);
    bus_stop();

    rd_burst(8'h0E, 4);

    // R7: NACK then silence
    bus_start();
    write_byte({DEV, 1'b0}, a);
    write_byte(8'h05, a);
    bus_start();
    write_byte({DEV, 1'b1}, a);
    read_byte(b, 1'b0);  chk("R7 first byte", b, em[8'h05]);
    read_byte(b, 1'b0);  chk("R7 silent after nack", b, 8'hFF);
    chk("R7 single pointer step", reg_addr, 8'h06);
    bus_stop();
    chk("R7 released after stop", sda_oe, 0);

    // Random bursts over incrementing, static and uncovered addresses
    for (int it = 0; it < 12; it++) begin
      p = 8'($urandom_range(0, 8'h2F));
      n = $urandom_range(1, 4);
      for (int k = 0; k < n; k++) dbuf[k] = 8'($urandom);
      wr_burst(p, n);
      rd_burst(p, n);
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errs);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    errs++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errs);
    $finish;
  end
endmodule